// File: doc/BRIEF.md
# UART Transmitter with SIR Encoding

This block turns characters taken from a transmit FIFO into asynchronous serial frames. Each frame has a start bit, 5 to 8 data bits, an optional parity bit and 1, 1.5 or 2 stop bits. The frame appears on a plain serial line or as active-low infrared SIR pulses. Timing comes from a single-cycle enable that pulses sixteen times per bit. The FIFO storage and the register interface sit outside the block. The block sees only the head entry, an empty flag and its own one-cycle pop strobe.

The frame shape is sampled at the instant a character is taken from the FIFO, so software may rewrite the line settings for the next character while the current one is still on the wire. Three controls change the outputs. Break forces a spacing condition, and its form depends on the mode. Loopback turns the frame onto an internal line for a local receiver. Halt holds characters back so the FIFO can be filled without draining.

Top module: `uart_tx_sir`

## Requirements
- R1: After reset, ser_out, sir_out_n and loop_out are high, busy is low, tx_empty is high and fifo_pop is low.
- R2: A frame is a low start bit, then the data bits least significant first, then the stop bits at high level. The count of data bits is 5 plus len_sel (00 gives 5, 11 gives 8). Every start, data and parity bit lasts exactly 16 baud_tick pulses, and the idle line is high.
- R3: With par_en high, a parity bit follows the last data bit. With par_even high it makes the number of ones in data plus parity even; with par_even low it makes that number odd.
- R4: With stop_sel low the stop time is 16 ticks. With stop_sel high it is 24 ticks when len_sel is 00, and 32 ticks otherwise.
- R5: fifo_pop is a one-cycle pulse, issued once per character as its frame begins. When the FIFO still holds data at the end of a stop time, the next start bit follows with no idle tick.
- R6: busy is high from the start bit through the end of the last stop bit. tx_empty is high only when fifo_empty is high and no frame is in progress.
- R7: While halt is high no new frame starts and no pop is issued. A frame already under way completes.
- R8: With sir_en high and loopback low, ser_out stays high. Each zero bit (start bit included) gives one low pulse on sir_out_n lasting 3 ticks from the bit's start, and each one bit gives no pulse.
- R9: With brk high and loopback low, ser_out is driven low for as long as brk stays high, whatever sir_en is.
- R10: With brk and sir_en high and loopback low, sir_out_n pulses low for 3 ticks once every 16 ticks, continuously.
- R11: With loopback high, ser_out stays high and loop_out carries the frame. With brk also high, loop_out and sir_out_n are both held low.
- R12: The length, parity and stop settings are captured when a character starts. Changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Enable, 16 pulses per bit time |
| fifo_empty | input | 1 | Transmit FIFO holds no entry |
| fifo_data | input | DW | Head entry of the transmit FIFO |
| len_sel | input | 2 | Data length code: bits = 5 + code |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| stop_sel | input | 1 | 0: one stop bit; 1: 1.5 (5-bit) or 2 stop bits |
| brk | input | 1 | Force a break condition |
| sir_en | input | 1 | Send on the infrared pulse output |
| loopback | input | 1 | Route the frame to loop_out instead of ser_out |
| halt | input | 1 | Hold off new characters |
| ser_out | output | 1 | Serial line, idle high |
| sir_out_n | output | 1 | SIR pulse output, active low |
| loop_out | output | 1 | Internal loopback line, idle high |
| fifo_pop | output | 1 | One-cycle pop strobe to the FIFO |
| busy | output | 1 | Frame in progress |
| tx_empty | output | 1 | FIFO empty and shifter idle |

## Verification
Some rules hold on every cycle and are checked by the assertions. The line changes only on a baud tick. The pop strobe lasts one cycle. A halted idle sequencer stays idle, and busy never coexists with tx_empty. An SIR pulse never outlasts three ticks. Break and loopback take hold of ser_out one cycle after they are raised. Only the bench's scenarios can show that decoded frames match the characters sent, along with parity polarity, the 24- and 32-tick stop times seen as frame-to-frame spacing, the count of SIR pulses per character, continuous pulsing during an SIR break, and settings captured per character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PAR,
    TX_STOP
  } tx_state_e;

  localparam int MIN_BITS = 5;

endpackage

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import uart_tx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     baud_tick,
  input  logic                     fifo_empty,
  input  logic [DW-1:0]            fifo_data,
  input  logic [1:0]               len_sel,
  input  logic                     par_en,
  input  logic                     par_even,
  input  logic                     stop_sel,
  input  logic                     halt,
  output logic                     line_q,
  output logic [$clog2(OVS)-1:0]   phase,
  output logic                     fifo_pop,
  output logic                     busy,
  output logic                     tx_empty
);

  localparam int PW = $clog2(OVS);
  localparam int CW = $clog2(2 * OVS);
  localparam int LW = $clog2(DW + 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OVS - 1);

  tx_state_e      st, st_n;
  logic [CW-1:0]  cnt, cnt_n;
  logic [DW-1:0]  sh, sh_n;
  logic [LW-1:0]  left, left_n;
  logic           line_n;
  logic           p_en, p_en_n, p_bit, p_bit_n;
  logic [CW-1:0]  stop_last, stop_last_n;
  logic           pop_q, empty_q;

  logic           can_start, load, at_end, par_raw;
  logic [DW-1:0]  mask;
  logic [PW-1:0]  ph_inc;

  assign can_start = !fifo_empty && !halt;
  assign mask      = ~({DW{1'b1}} << (MIN_BITS + int'(len_sel)));
  assign par_raw   = ^(fifo_data & mask);
  assign ph_inc    = cnt[PW-1:0] + 1'b1;
  assign at_end    = (st == TX_STOP) ? (cnt == stop_last) : (cnt == BIT_LAST);

  always_comb begin
    st_n        = st;
    cnt_n       = cnt;
    sh_n        = sh;
    left_n      = left;
    line_n      = line_q;
    p_en_n      = p_en;
    p_bit_n     = p_bit;
    stop_last_n = stop_last;
    load        = 1'b0;
    if (baud_tick) begin
      if (st == TX_IDLE) begin
        if (can_start) load = 1'b1;
        else           cnt_n = CW'(ph_inc);
      end else if (!at_end) begin
        cnt_n = cnt + 1'b1;
      end else begin
        cnt_n = '0;
        if (st == TX_START) begin
          st_n   = TX_DATA;
          line_n = sh[0];
          sh_n   = sh >> 1;
          left_n = left - 1'b1;
        end else if (st == TX_DATA) begin
          if (left == '0) begin
            st_n   = p_en ? TX_PAR : TX_STOP;
            line_n = p_en ? p_bit : 1'b1;
          end else begin
            line_n = sh[0];
            sh_n   = sh >> 1;
            left_n = left - 1'b1;
          end
        end else if (st == TX_PAR) begin
          st_n   = TX_STOP;
          line_n = 1'b1;
        end else begin
          if (can_start) load = 1'b1;
          else           st_n = TX_IDLE;
        end
      end
    end
    if (load) begin
      st_n        = TX_START;
      cnt_n       = '0;
      line_n      = 1'b0;
      sh_n        = fifo_data;
      left_n      = LW'(MIN_BITS) + LW'(len_sel);
      p_en_n      = par_en;
      p_bit_n     = par_even ? par_raw : ~par_raw;
      stop_last_n = !stop_sel ? BIT_LAST : ((len_sel == 2'b00) ? HALF_LAST : TWO_LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= TX_IDLE;
      cnt       <= '0;
      sh        <= '0;
      left      <= '0;
      line_q    <= 1'b1;
      p_en      <= 1'b0;
      p_bit     <= 1'b0;
      stop_last <= BIT_LAST;
      pop_q     <= 1'b0;
      empty_q   <= 1'b1;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      sh        <= sh_n;
      left      <= left_n;
      line_q    <= line_n;
      p_en      <= p_en_n;
      p_bit     <= p_bit_n;
      stop_last <= stop_last_n;
      pop_q     <= load;
      empty_q   <= fifo_empty && (st_n == TX_IDLE);
    end
  end

  assign phase    = cnt[PW-1:0];
  assign fifo_pop = pop_q;
  assign busy     = (st != TX_IDLE);
  assign tx_empty = empty_q;

  // R2
  line_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(line_q));

  // R5
  pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  // R6
  busy_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_empty);

  // R7
  halt_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == TX_IDLE && halt) |=> (st == TX_IDLE));

endmodule

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc #(
  parameter int OVS   = 16,
  parameter int PULSE = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   baud_tick,
  input  logic                   bit_val,
  input  logic [$clog2(OVS)-1:0] phase,
  output logic                   pulse
);

  localparam int PW = $clog2(OVS);
  localparam int LW = $clog2(PULSE + 2);

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= !bit_val && (phase < PW'(PULSE));
  end

  logic [LW-1:0] plen;
  always_ff @(posedge clk) begin
    if (rst || !pulse)  plen <= '0;
    else if (baud_tick) plen <= plen + 1'b1;
  end

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (plen <= LW'(PULSE)));

endmodule

// File: rtl/tx_line_out.sv
module tx_line_out (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic pulse,
  input  logic brk,
  input  logic sir_en,
  input  logic loopback,
  output logic ser_out,
  output logic sir_out_n,
  output logic loop_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out   <= 1'b1;
      sir_out_n <= 1'b1;
      loop_out  <= 1'b1;
    end else begin
      ser_out   <= loopback ? 1'b1 : (brk ? 1'b0 : (sir_en ? 1'b1 : line));
      sir_out_n <= loopback ? ~brk : (sir_en ? ~pulse : 1'b1);
      loop_out  <= loopback ? (line & ~brk) : 1'b1;
    end
  end

  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    (brk && !loopback) |=> !ser_out);

  // R11
  loop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    loopback |=> ser_out);

  // R8
  sir_quiet_ser_chk: assert property (@(posedge clk) disable iff (rst)
    (sir_en && !brk && !loopback) |=> ser_out);

endmodule

// File: rtl/uart_tx_sir.sv
module uart_tx_sir #(
  parameter int DW        = 8,
  parameter int OVS       = 16,
  parameter int SIR_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          stop_sel,
  input  logic          brk,
  input  logic          sir_en,
  input  logic          loopback,
  input  logic          halt,
  output logic          ser_out,
  output logic          sir_out_n,
  output logic          loop_out,
  output logic          fifo_pop,
  output logic          busy,
  output logic          tx_empty
);

  localparam int PW = $clog2(OVS);

  logic          line;
  logic [PW-1:0] phase;
  logic          pulse;

  tx_frame_seq #(.DW(DW), .OVS(OVS)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .len_sel    (len_sel),
    .par_en     (par_en),
    .par_even   (par_even),
    .stop_sel   (stop_sel),
    .halt       (halt),
    .line_q     (line),
    .phase      (phase),
    .fifo_pop   (fifo_pop),
    .busy       (busy),
    .tx_empty   (tx_empty)
  );

  sir_pulse_enc #(.OVS(OVS), .PULSE(SIR_PULSE)) u_sir (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (baud_tick),
    .bit_val   (line & ~brk),
    .phase     (phase),
    .pulse     (pulse)
  );

  tx_line_out u_out (
    .clk       (clk),
    .rst       (rst),
    .line      (line),
    .pulse     (pulse),
    .brk       (brk),
    .sir_en    (sir_en),
    .loopback  (loopback),
    .ser_out   (ser_out),
    .sir_out_n (sir_out_n),
    .loop_out  (loop_out)
  );

endmodule

// File: tb/uart_tx_sir_test.sv
module uart_tx_sir_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic fifo_empty = 1'b1;
  logic [7:0] fifo_data = 8'h00;
  logic [1:0] len_sel = 2'b11;
  logic par_en = 1'b0, par_even = 1'b0, stop_sel = 1'b0;
  logic brk = 1'b0, sir_en = 1'b0, loopback = 1'b0, halt = 1'b0;
  logic ser_out, sir_out_n, loop_out, fifo_pop, busy, tx_empty;

  uart_tx_sir uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .len_sel(len_sel), .par_en(par_en),
    .par_even(par_even), .stop_sel(stop_sel), .brk(brk), .sir_en(sir_en),
    .loopback(loopback), .halt(halt), .ser_out(ser_out),
    .sir_out_n(sir_out_n), .loop_out(loop_out), .fifo_pop(fifo_pop),
    .busy(busy), .tx_empty(tx_empty)
  );

  initial forever #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int cyc = 0;
  int n_pops = 0, ser_lows = 0, sir_falls = 0, sir_w = 0, frames = 0;
  bit w_chk = 1, mon_on = 1, mon_sel = 0, sir_prev = 1;
  int m_len = 8;
  bit m_par = 0, m_even = 0;
  logic [7:0] fq[$];
  logic [7:0] exp_q[$];
  int starts[$];

  task automatic chk_eq(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial forever begin @(posedge clk); cyc++; end

  // Baud enable: one pulse every 4 clocks
  initial begin
    logic [1:0] tdiv = 2'd0;
    forever begin
      @(negedge clk);
      tdiv = tdiv + 2'd1;
      baud_tick = (tdiv == 2'd0);
    end
  end

  // FIFO model
  initial forever begin
    @(negedge clk);
    if (fifo_pop) begin
      if (fq.size() > 0) void'(fq.pop_front());
      n_pops++;
    end
    fifo_empty = (fq.size() == 0);
    fifo_data  = (fq.size() > 0) ? fq[0] : 8'h00;
  end

  // Scoreboard monitor: decodes frames, compares with expected queue
  wire mon_line = mon_sel ? loop_out : ser_out;
  initial forever begin
    @(negedge clk);
    if (mon_on && mon_line == 1'b0) begin
      logic [7:0] got;
      logic [7:0] exp;
      logic pb;
      starts.push_back(cyc);
      frames++;
      got = 8'h00;
      repeat (32) @(negedge clk);
      chk_eq(mon_line, 0, "R2 start bit");
      for (int i = 0; i < m_len; i++) begin
        repeat (64) @(negedge clk);
        got[i] = mon_line;
      end
      if (m_par) begin
        repeat (64) @(negedge clk);
        pb = m_even ? ^got : ~^got;
        chk_eq(mon_line, pb, "R3 parity bit");
      end
      repeat (64) @(negedge clk);
      chk_eq(mon_line, 1, "R2 stop bit");
      exp = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
      chk_eq(got, exp, "R2 data bits");
    end
  end

  // Line watcher: ser_out low count, SIR pulse count and width
  initial forever begin
    @(negedge clk);
    if (ser_out == 1'b0) ser_lows++;
    if (sir_prev && !sir_out_n) begin sir_falls++; sir_w = 0; end
    if (!sir_out_n) sir_w++;
    if (!sir_prev && sir_out_n && w_chk) chk_eq(sir_w, 12, "R8 R10 SIR pulse width");
    sir_prev = sir_out_n;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_cfg(input int len, input bit p, input bit ev, input bit st);
    len_sel = 2'(len - 5); par_en = p; par_even = ev; stop_sel = st;
    m_len = len; m_par = p; m_even = ev;
  endtask

  task automatic send(input logic [7:0] b);
    fq.push_back(b);
    exp_q.push_back(b & (8'hFF >> (8 - m_len)));
  endtask

  task automatic wait_idle();
    wait_clk(4);
    while (fq.size() != 0 || busy) wait_clk(1);
    wait_clk(8);
  endtask

  task automatic chk_period(input int exp, input string tag);
    for (int i = 1; i < starts.size(); i++) chk_eq(starts[i] - starts[i-1], exp, tag);
    starts.delete();
  endtask

  initial begin
    int p0, f0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    chk_eq(ser_out, 1, "R1 ser_out"); chk_eq(sir_out_n, 1, "R1 sir_out_n");
    chk_eq(loop_out, 1, "R1 loop_out"); chk_eq(busy, 0, "R1 busy");
    chk_eq(tx_empty, 1, "R1 tx_empty"); chk_eq(fifo_pop, 0, "R1 fifo_pop");

    // R2 R5 R6: 8 data bits, no parity, 1 stop, back to back
    set_cfg(8, 0, 0, 0);
    starts.delete();
    p0 = n_pops;
    send(8'hA5); send(8'h3C); send(8'h00); send(8'hFF);
    wait_clk(100);
    chk_eq(busy, 1, "R6 busy mid-frame");
    chk_eq(tx_empty, 0, "R6 tx_empty mid-frame");
    wait_idle();
    chk_eq(n_pops - p0, 4, "R5 pop count");
    chk_period(640, "R5 8N1 frame spacing");
    chk_eq(busy, 0, "R6 busy after");
    chk_eq(tx_empty, 1, "R6 tx_empty after");
    chk_eq(exp_q.size(), 0, "R2 all frames seen");

    // R3 R4: 5 bits, even parity, 1.5 stop
    set_cfg(5, 1, 1, 1);
    send(8'h13); send(8'h0E);
    wait_idle();
    chk_period(544, "R4 1.5 stop spacing");

    // R3 R4: 7 bits, odd parity, 2 stop
    set_cfg(7, 1, 0, 1);
    send(8'h55); send(8'h7F);
    wait_idle();
    chk_period(704, "R4 2 stop spacing");

    // R2 R4: 6 bits, no parity, 1 stop
    set_cfg(6, 0, 0, 0);
    send(8'h2A); send(8'h15);
    wait_idle();
    chk_period(512, "R4 1 stop 6-bit spacing");

    // R7 halt before data
    set_cfg(8, 0, 0, 0);
    halt = 1'b1;
    p0 = n_pops; f0 = frames;
    send(8'h11); send(8'h22);
    wait_clk(1000);
    chk_eq(n_pops - p0, 0, "R7 no pop while halted");
    chk_eq(frames - f0, 0, "R7 no frame while halted");
    chk_eq(busy, 0, "R7 busy while halted");
    chk_eq(tx_empty, 0, "R6 tx_empty with data held");
    halt = 1'b0;
    wait_idle();
    chk_eq(frames - f0, 2, "R7 frames after release");
    starts.delete();

    // R7 halt during a frame
    f0 = frames;
    send(8'h81); send(8'h42);
    wait_clk(100);
    halt = 1'b1;
    wait_clk(900);
    chk_eq(frames - f0, 1, "R7 current frame completes");
    chk_eq(fq.size(), 1, "R7 second char held");
    halt = 1'b0;
    wait_idle();
    starts.delete();

    // R12 settings captured at start
    send(8'hB7);
    wait_clk(100);
    len_sel = 2'b00; par_en = 1'b1; stop_sel = 1'b1;
    wait_idle();
    chk_eq(exp_q.size(), 0, "R12 frame kept 8 bits");
    set_cfg(8, 0, 0, 0);
    wait_clk(200);
    starts.delete();

    // R8 SIR encoding
    mon_on = 0;
    sir_en = 1'b1;
    wait_clk(20);
    sir_falls = 0; ser_lows = 0;
    fq.push_back(8'h55); fq.push_back(8'h81);
    wait_idle();
    chk_eq(sir_falls, 12, "R8 SIR pulse count");
    chk_eq(ser_lows, 0, "R8 ser_out idle in SIR");

    // R10 SIR break
    w_chk = 0;
    brk = 1'b1;
    wait_clk(100);
    w_chk = 1;
    sir_falls = 0;
    wait_clk(640);
    chk_eq(sir_falls, 10, "R10 break pulses per 16 ticks");
    w_chk = 0;
    brk = 1'b0;
    wait_clk(100);
    w_chk = 1;
    sir_en = 1'b0;
    wait_clk(20);

    // R9 plain break
    brk = 1'b1;
    wait_clk(3);
    chk_eq(ser_out, 0, "R9 ser_out low on break");
    ser_lows = 0;
    wait_clk(400);
    chk_eq(ser_lows, 400, "R9 ser_out held low");
    brk = 1'b0;
    wait_clk(3);
    chk_eq(ser_out, 1, "R9 ser_out released");

    // R11 loopback
    loopback = 1'b1;
    mon_sel = 1; mon_on = 1;
    wait_clk(20);
    ser_lows = 0;
    send(8'hC3);
    wait_idle();
    chk_eq(exp_q.size(), 0, "R11 frame on loop_out");
    chk_eq(ser_lows, 0, "R11 ser_out quiet in loopback");
    mon_on = 0;
    w_chk = 0;
    brk = 1'b1;
    wait_clk(3);
    chk_eq(loop_out, 0, "R11 loop_out low on break");
    chk_eq(sir_out_n, 0, "R11 sir_out_n low on break");
    chk_eq(ser_out, 1, "R11 ser_out high on break");
    brk = 1'b0;
    loopback = 1'b0;
    wait_clk(20);
    finish_run();
  end

endmodule